// File: doc/BRIEF.md
# Two-Stage Rotating Load-Balanced Cell Switch

This block is an N-port cell switch. It has no request/grant scheduler. Cells cross two fixed crossbar stages. Each stage's connection pattern rotates by one position every clock, so each pattern depends only on a free-running slot counter.

In the first stage, a cell that arrives on an input is steered to whichever intermediate port that input faces in the current slot. The cell is stored there in the queue that belongs to its final output. Because the rotation visits every intermediate port once per N slots, traffic from each input is spread evenly across the middle of the switch.

In the second stage, every intermediate port faces one output per slot. It forwards the head of that output's queue. Cells of one flow can take different intermediate ports, so they may leave the switch out of order. The block accepts this and does nothing to restore order.

Top module: `lbs_switch`

## Requirements
- R1: While `rst` is high at a clock edge, all queues are emptied, the slot counter returns to 0 and `drop_count` returns to 0. From the edge after that, `out_valid` is all zeros until a cell is forwarded.
- R2: The slot counter t is 0 in the first clock edge after reset is released. It then advances by one per edge and wraps from N-1 to 0.
- R3: At slot t, a valid cell on input i is offered to intermediate port (i + t) mod N. If accepted, it is appended to that port's queue for output `in_dest[i]`. Inputs are packed: input i uses `in_dest[i*PW +: PW]` and `in_data[i*DW +: DW]`, where PW = clog2(N).
- R4: At slot t, intermediate port k serves output (k + t) mod N. If that queue holds a cell at the edge, its head is removed and appears on `out_valid[j]` and `out_data[j*DW +: DW]` of that output from that edge until the next one. This gives one register of latency.
- R5: If the served queue is empty at the edge, that output shows `out_valid` low for the slot. A cell pushed in the same edge is not served in that edge.
- R6: If the queue targeted by an arriving cell already holds DEPTH cells at the edge, the cell is discarded. This holds even if the same queue is served in that edge. `drop_count` then increases by the number of cells discarded in that edge, wrapping at 2^CW.
- R7: Within one queue, cells leave in arrival order, and each payload arrives unchanged. Cells of one flow may still reach the output out of order across intermediate ports.
- R8: A valid input cell must carry a destination below N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one slot per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | N | Cell present on each input |
| in_dest | input | N*PW | Destination output of each input cell |
| in_data | input | N*DW | Payload of each input cell |
| out_valid | output | N | Cell present on each output (registered) |
| out_data | output | N*DW | Payload on each output (registered) |
| drop_count | output | CW | Running count of discarded cells |

## Verification
On every cycle, the in-line assertions check the following:
- the slot counter's range and wrap;
- that no queue is pushed while full or popped while empty;
- that queue occupancy stays within bounds;
- that destinations stay in range;
- that the drop count moves only when cells were offered;
- that outputs are quiet right after reset.

The mapping of each input to the correct intermediate port and output in each slot, per-queue ordering, payload integrity, the exact slot in which a cell emerges, and the exact drop arithmetic under saturation can only be shown by the bench. The bench compares every output against an independent queue model under single-cell, uniform random and hotspot traffic.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
  // (a + b) mod n for a, b < n
  function automatic int unsigned lbs_wrap_add(input int unsigned a, input int unsigned b,
                                               input int unsigned n);
    int unsigned s;
    s = a + b;
    if (s >= n) s = s - n;
    return s;
  endfunction

  // (a - b) mod n for a, b < n
  function automatic int unsigned lbs_wrap_sub(input int unsigned a, input int unsigned b,
                                               input int unsigned n);
    int unsigned s;
    s = a + n - b;
    if (s >= n) s = s - n;
    return s;
  endfunction
endpackage

// File: rtl/lbs_slot_ctr.sv
module lbs_slot_ctr #(
  parameter int N  = 4,
  parameter int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  output logic [PW-1:0] slot
);
  always_ff @(posedge clk) begin
    if (rst)                    slot <= '0;
    else if (slot == PW'(N-1))  slot <= '0;
    else                        slot <= slot + 1'b1;
  end

  a_r2_slot_wrap: assert property (@(posedge clk) disable iff (rst)
    (slot == PW'(N-1)) |=> (slot == '0));
  a_r2_slot_range: assert property (@(posedge clk) disable iff (rst)
    (int'(slot) < N));
endmodule

// File: rtl/lbs_cell_fifo.sv
module lbs_cell_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          nonempty,
  output logic          full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [DW-1:0]   mem [DEPTH];
  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic [CNTW-1:0] fill;

  // storage has no reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  assign head     = mem[rd_ptr];
  assign nonempty = (fill != '0);
  assign full     = (fill == CNTW'(DEPTH));

  a_r6_no_push_when_full: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  a_r5_no_pop_when_empty: assert property (@(posedge clk) disable iff (rst)
    pop |-> nonempty);
  a_r6_fill_bound: assert property (@(posedge clk) disable iff (rst)
    int'(fill) <= DEPTH);
endmodule

// File: rtl/lbs_mid_port.sv
module lbs_mid_port
  import lbs_pkg::*;
#(
  parameter int N     = 4,
  parameter int PW    = (N > 1) ? $clog2(N) : 1,
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int IDX   = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] slot,
  input  logic          cell_valid,
  input  logic [PW-1:0] cell_dest,
  input  logic [DW-1:0] cell_data,
  output logic          sel_valid,
  output logic [DW-1:0] sel_data,
  output logic          drop
);
  logic [N-1:0]  push_w, pop_w, nonempty_w, full_w;
  logic [DW-1:0] head_w [N];
  logic [PW-1:0] serve_q;

  // second-stage rotation: this port faces output (IDX + t) mod N
  always_comb serve_q = PW'(lbs_wrap_add(IDX, int'(slot), N));

  for (genvar q = 0; q < N; q++) begin : g_q
    assign push_w[q] = cell_valid && (cell_dest == PW'(q)) && !full_w[q];
    assign pop_w[q]  = (serve_q == PW'(q)) && nonempty_w[q];
    lbs_cell_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk      (clk),
      .rst      (rst),
      .push     (push_w[q]),
      .push_data(cell_data),
      .pop      (pop_w[q]),
      .head     (head_w[q]),
      .nonempty (nonempty_w[q]),
      .full     (full_w[q])
    );
  end

  assign sel_valid = nonempty_w[serve_q];
  assign sel_data  = head_w[serve_q];
  assign drop      = cell_valid && full_w[cell_dest];

  a_r4_single_pop: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pop_w));
  a_r3_single_push: assert property (@(posedge clk) disable iff (rst)
    $onehot0(push_w));
endmodule

// File: rtl/lbs_switch.sv
module lbs_switch
  import lbs_pkg::*;
#(
  parameter int N     = 4,
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int CW    = 16,
  localparam int PW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    in_valid,
  input  logic [N*PW-1:0] in_dest,
  input  logic [N*DW-1:0] in_data,
  output logic [N-1:0]    out_valid,
  output logic [N*DW-1:0] out_data,
  output logic [CW-1:0]   drop_count
);
  logic [PW-1:0] slot;
  logic [N-1:0]  mid_valid, sel_valid, drop_vec;
  logic [PW-1:0] mid_dest [N];
  logic [DW-1:0] mid_data [N];
  logic [DW-1:0] sel_data [N];

  lbs_slot_ctr #(.N(N), .PW(PW)) u_slot (
    .clk (clk),
    .rst (rst),
    .slot(slot)
  );

  // stage one: intermediate port k listens to input (k - t) mod N
  for (genvar k = 0; k < N; k++) begin : g_mid
    logic [PW-1:0] src;
    always_comb src = PW'(lbs_wrap_sub(k, int'(slot), N));
    assign mid_valid[k] = in_valid[src];
    assign mid_dest[k]  = in_dest[src*PW +: PW];
    assign mid_data[k]  = in_data[src*DW +: DW];

    lbs_mid_port #(.N(N), .PW(PW), .DW(DW), .DEPTH(DEPTH), .IDX(k)) u_mid (
      .clk       (clk),
      .rst       (rst),
      .slot      (slot),
      .cell_valid(mid_valid[k]),
      .cell_dest (mid_dest[k]),
      .cell_data (mid_data[k]),
      .sel_valid (sel_valid[k]),
      .sel_data  (sel_data[k]),
      .drop      (drop_vec[k])
    );
  end

  // stage two: output j is fed by intermediate port (j - t) mod N
  for (genvar j = 0; j < N; j++) begin : g_out
    logic [PW-1:0] feeder;
    always_comb feeder = PW'(lbs_wrap_sub(j, int'(slot), N));
    always_ff @(posedge clk) begin
      if (rst) begin
        out_valid[j]           <= 1'b0;
        out_data[j*DW +: DW]   <= '0;
      end else begin
        out_valid[j]           <= sel_valid[feeder];
        out_data[j*DW +: DW]   <= sel_data[feeder];
      end
    end

    a_r8_dest_range: assert property (@(posedge clk) disable iff (rst)
      in_valid[j] |-> (int'(in_dest[j*PW +: PW]) < N));
  end

  always_ff @(posedge clk) begin
    if (rst) drop_count <= '0;
    else     drop_count <= drop_count + CW'($countones(drop_vec));
  end

  a_r6_drop_needs_traffic: assert property (@(posedge clk) disable iff (rst)
    !$stable(drop_count) |-> $past(|in_valid));
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (out_valid == '0 && drop_count == '0));
endmodule

// File: tb/lbs_switch_test.sv
module lbs_switch_test;
  localparam int N = 4, DW = 16, DEPTH = 4, CW = 16, PW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5ns clk = ~clk;

  logic [N-1:0]    in_valid = '0;
  logic [N*PW-1:0] in_dest  = '0;
  logic [N*DW-1:0] in_data  = '0;
  logic [N-1:0]    out_valid;
  logic [N*DW-1:0] out_data;
  logic [CW-1:0]   drop_count;

  lbs_switch #(.N(N), .DW(DW), .DEPTH(DEPTH), .CW(CW)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_dest(in_dest), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .drop_count(drop_count)
  );

  int unsigned n_cmp = 0, n_bad = 0;
  string req = "R1";

  // behavioural reference: one queue per (intermediate, output) pair
  int mq [N][N][$];
  int mt = 0;
  bit ev [N];
  int ed [N];
  int edrop = 0;

  always @(posedge clk) begin : model
    int sz [N][N];
    if (rst) begin
      for (int m = 0; m < N; m++) for (int q = 0; q < N; q++) mq[m][q].delete();
      mt = 0; edrop = 0;
      for (int j = 0; j < N; j++) begin ev[j] = 0; ed[j] = 0; end
    end else begin
      for (int m = 0; m < N; m++) for (int q = 0; q < N; q++) sz[m][q] = mq[m][q].size();
      for (int j = 0; j < N; j++) begin
        int m;
        m = (j - mt + N) % N;
        if (sz[m][j] > 0) begin ev[j] = 1; ed[j] = mq[m][j].pop_front(); end
        else ev[j] = 0;
      end
      for (int i = 0; i < N; i++) if (in_valid[i]) begin
        int m, d;
        m = (i + mt) % N;
        d = int'(in_dest[i*PW +: PW]);
        if (sz[m][d] >= DEPTH) edrop++;
        else mq[m][d].push_back(int'(in_data[i*DW +: DW]));
      end
      mt = (mt + 1) % N;
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    for (int j = 0; j < N; j++) begin
      chk(out_valid[j] == ev[j], $sformatf("out_valid[%0d]", j), int'(out_valid[j]), int'(ev[j]));
      if (ev[j] && out_valid[j])
        chk(int'(out_data[j*DW +: DW]) == ed[j], $sformatf("out_data[%0d]", j),
            int'(out_data[j*DW +: DW]), ed[j]);
    end
    chk(drop_count == CW'(edrop), "drop_count", int'(drop_count), edrop % (1 << CW));
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
  endtask

  int tag = 1;

  task automatic drive(input bit [N-1:0] v, input int dests [N]);
    for (int i = 0; i < N; i++) begin
      in_dest[i*PW +: PW] = PW'(dests[i]);
      in_data[i*DW +: DW] = DW'(tag);
      tag++;
    end
    in_valid = v;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    #(5ns * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : stim
    int d [N];
    repeat (3) @(negedge clk);
    req = "R1";
    chk(out_valid == '0, "reset out_valid", int'(out_valid), 0);
    chk(drop_count == '0, "reset drop_count", int'(drop_count), 0);
    @(negedge clk);
    rst = 1'b0;

    // R4/R5/R2: one cell, input 0 to output 0 at slot 0; emerges after one full rotation
    req = "R4";
    for (int i = 0; i < N; i++) d[i] = 0;
    drive(4'b0001, d);
    step();
    in_valid = '0;
    for (int c = 0; c < 3; c++) begin
      req = "R5";
      chk(out_valid[0] == 1'b0, "early out_valid[0]", int'(out_valid[0]), 0);
      step();
    end
    req = "R4";
    step();
    chk(out_valid[0] == 1'b1, "rotation latency out_valid[0]", int'(out_valid[0]), 1);
    chk(int'(out_data[DW-1:0]) == tag - N, "rotation payload", int'(out_data[DW-1:0]), tag - N);
    repeat (4) step();

    // R3/R7: uniform random traffic at moderate load
    req = "R3";
    for (int c = 0; c < 400; c++) begin
      bit [N-1:0] v;
      for (int i = 0; i < N; i++) d[i] = int'($urandom_range(N-1));
      v = N'($urandom) & N'($urandom);
      drive(v, d);
      step();
    end
    in_valid = '0;
    req = "R7";
    repeat (40) step();

    // R6: hotspot to output 1 saturates queues and forces drops
    req = "R6";
    for (int c = 0; c < 60; c++) begin
      for (int i = 0; i < N; i++) d[i] = 1;
      drive('1, d);
      step();
    end
    in_valid = '0;
    chk(drop_count != '0, "hotspot produced drops", int'(drop_count), edrop);
    req = "R5";
    repeat (40) step();
    chk(out_valid == '0, "drained idle outputs", int'(out_valid), 0);

    // R7: full load, random destinations
    req = "R7";
    for (int c = 0; c < 300; c++) begin
      for (int i = 0; i < N; i++) d[i] = int'($urandom_range(N-1));
      drive('1, d);
      step();
    end
    in_valid = '0;
    repeat (40) step();

    // R1: mid-traffic reset clears everything
    req = "R1";
    for (int i = 0; i < N; i++) d[i] = i;
    drive('1, d);
    step();
    rst = 1'b1;
    in_valid = '0;
    step();
    step();
    rst = 1'b0;
    chk(out_valid == '0, "post-reset out_valid", int'(out_valid), 0);
    chk(drop_count == '0, "post-reset drop_count", int'(drop_count), 0);
    repeat (10) step();

    finish_run();
  end
endmodule